// File: doc/BRIEF.md
# Bus Suspend Controller for a Serial Memory Slave

This block sits beside the command engine of a serial memory slave. It decides, on every system clock, whether the engine may advance and whether the engine's serial output driver may be enabled. Two conditions stop the engine.

The first is the active-low hold pin. A host pulls it low to freeze a transfer in the middle of a byte, and releases it later to carry on from the same bit. Hold edges are taken only while the serial clock is low. An edge that arrives while the serial clock is high waits until the clock next goes low.

The second condition is a low-power sleep state. The engine raises a one-cycle strobe when it has decoded the sleep command in the current frame. Sleep begins when chip select rises at the end of that frame. While asleep, the serial clock, the hold pin and the strobe are ignored, but chip select is still watched. The next chip-select fall starts a recovery window of `WAKE_CYCLES` system-clock cycles. During that window the block reports busy, which the engine shows as status bit 0, and the output stays disabled. If the frame that started the wakeup is still open when the window ends, that frame is thrown away. The engine then stays stopped until chip select goes high, and work resumes with the next fresh frame.

All pin inputs are taken as already sampled into the system-clock domain. A chip-select edge is seen by comparing the present input with its value one cycle earlier.

Top module: `bus_suspend_ctrl`

## Requirements
- R1: After reset, `run_en` is 1, `wake_busy` is 0, and the controller is awake with no sleep request pending.
- R2: When `sck` is sampled 0, the hold state takes the value of `!hold_n` at that clock edge. One cycle later, `run_en` is 0 while hold is active and 1 again once hold is released (when awake).
- R3: When `sck` is sampled 1, the hold state keeps its previous value whatever `hold_n` does. A pending edge therefore takes effect at the first edge where `sck` is 0.
- R4: `so_oe` is 1 only when `run_en` is 1 and `cs_n` is currently 0; otherwise it is 0.
- R5: If `sleep_cmd` is 1 on any cycle with `cs_n` at 0 while awake, the next chip-select rise (`cs_n` 1 now, 0 the cycle before) puts the block to sleep. While asleep, `run_en` and `so_oe` are 0, and `sck`, `hold_n` and `sleep_cmd` have no effect.
- R6: A chip-select rise ending a frame with no `sleep_cmd` leaves the block awake. A request is cleared by every chip-select rise, so it never carries over into a later frame.
- R7: A chip-select fall while asleep starts the wakeup. `wake_busy` is then 1 for exactly `WAKE_CYCLES` samples, during which `run_en` and `so_oe` are 0. Chip-select changes during this window have no effect.
- R8: If `cs_n` is 1 at the edge where the window ends, `run_en` is 1 in the same sample where `wake_busy` first reads 0.
- R9: If `cs_n` is 0 at the edge where the window ends, `run_en` stays 0 until an edge where `cs_n` is 1, and is 1 from the next sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Sampled chip select, active low |
| sck | input | 1 | Sampled serial clock level |
| hold_n | input | 1 | Sampled hold pin, active low |
| sleep_cmd | input | 1 | One-cycle strobe: sleep command decoded in this frame |
| run_en | output | 1 | Engine may advance |
| so_oe | output | 1 | Serial output driver may be enabled |
| wake_busy | output | 1 | Recovery window in progress (status bit 0) |

## Verification
The bench sweeps every pair of consecutive `sck`/`hold_n` values. A design that acted on hold edges while the clock was high would corrupt the bit being shifted, and one that lost a deferred edge would leave the engine frozen or running at the wrong time.

The length of the busy window is counted exactly, in cycles. An off-by-one in the recovery counter shows up as one sample too many or too few.

A wakeup is also driven with chip select held low through the end of the window. A design that resumed at once would execute a frame whose opening bits it never saw. Frames without the sleep strobe are run after a sleeping frame, to catch a request that leaks into the next frame. A long pseudo-random run is then compared against an arithmetic model of the block.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    PM_AWAKE  = 2'd0,
    PM_ASLEEP = 2'd1,
    PM_WAKING = 2'd2,
    PM_STALE  = 2'd3
  } pm_state_t;

  // Hold flag update: follows the pin only while the serial clock is low.
  function automatic logic hold_next(input logic cur, input logic sck_lvl,
                                     input logic hold_pin_n);
    return sck_lvl ? cur : ~hold_pin_n;
  endfunction

  // Last cycle of the recovery window.
  function automatic logic wake_last(input logic [31:0] cnt,
                                     input int unsigned lim);
    return cnt == 32'(lim - 1);
  endfunction

endpackage

// File: rtl/bsc_hold_gate.sv
module bsc_hold_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic hold_n,
  output logic held
);
  import bsc_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= hold_next(held, sck, hold_n);
  end

  // R3
  hold_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held != $past(held)) |-> !$past(sck));

  // R2
  hold_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck |=> (held == !$past(hold_n)));

endmodule

// File: rtl/bsc_sleep_fsm.sv
module bsc_sleep_fsm #(
  parameter int unsigned WAKE_CYCLES = 90000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sleep_cmd,
  output logic active,
  output logic busy
);
  import bsc_pkg::*;

  localparam int unsigned CW = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);

  pm_state_t state;
  logic      cs_q;
  logic      armed;
  logic [CW-1:0] cnt;

  wire cs_rise = cs_n & ~cs_q;
  wire cs_fall = ~cs_n & cs_q;
  wire win_end = wake_last(32'(cnt), WAKE_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PM_AWAKE;
      cs_q  <= 1'b1;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      cs_q <= cs_n;
      case (state)
        PM_AWAKE: begin
          if (sleep_cmd && !cs_n) armed <= 1'b1;
          if (cs_rise) begin
            armed <= 1'b0;
            if (armed) state <= PM_ASLEEP;
          end
        end
        PM_ASLEEP: begin
          if (cs_fall) begin
            state <= PM_WAKING;
            cnt   <= '0;
          end
        end
        PM_WAKING: begin
          if (win_end) state <= cs_n ? PM_AWAKE : PM_STALE;
          else         cnt   <= cnt + 1'b1;
        end
        default: begin
          if (cs_n) state <= PM_AWAKE;
        end
      endcase
    end
  end

  assign active = (state == PM_AWAKE);
  assign busy   = (state == PM_WAKING);

  // R5
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PM_ASLEEP && $past(state) != PM_ASLEEP) |-> ($past(cs_n) && !$past(cs_q)));

  // R7
  wake_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (32'($past(cnt)) == 32'(WAKE_CYCLES - 1)));

  // R9
  stale_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == PM_STALE && state == PM_AWAKE) |-> $past(cs_n));

endmodule

// File: rtl/bus_suspend_ctrl.sv
module bus_suspend_ctrl #(
  parameter int unsigned WAKE_CYCLES = 90000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic hold_n,
  input  logic sleep_cmd,
  output logic run_en,
  output logic so_oe,
  output logic wake_busy
);

  logic held;
  logic active;

  bsc_hold_gate u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck    (sck),
    .hold_n (hold_n),
    .held   (held)
  );

  bsc_sleep_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_sleep (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .sleep_cmd (sleep_cmd),
    .active    (active),
    .busy      (wake_busy)
  );

  assign run_en = active & ~held;
  assign so_oe  = run_en & ~cs_n;

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_busy |-> (!run_en && !so_oe));

  // R4
  oe_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !so_oe);

endmodule

// File: tb/tb_bus_suspend_ctrl.sv
module tb_bus_suspend_ctrl;
  localparam int unsigned W = 6;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, hold_n, sleep_cmd;
  logic run_en, so_oe, wake_busy;

  int vecs  = 0;
  int fails = 0;

  // model state: mode 0 awake, 1 asleep, 2 waking, 3 stale
  int   m_mode;
  int   m_left;
  logic m_held, m_arm, m_csq;

  always #2.5 clk = ~clk;

  bus_suspend_ctrl #(.WAKE_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
    .sleep_cmd(sleep_cmd), .run_en(run_en), .so_oe(so_oe), .wake_busy(wake_busy)
  );

  task automatic model_reset();
    m_mode = 0; m_left = 0; m_held = 1'b0; m_arm = 1'b0; m_csq = 1'b1;
  endtask

  task automatic model_step();
    logic nh;
    nh = sck ? m_held : !hold_n;
    case (m_mode)
      0: begin
        if (sleep_cmd && !cs_n) m_arm = 1'b1;
        if (cs_n && !m_csq) begin
          if (m_arm) m_mode = 1;
          m_arm = 1'b0;
        end
      end
      1: if (!cs_n && m_csq) begin m_mode = 2; m_left = W; end
      2: begin
        m_left = m_left - 1;
        if (m_left == 0) m_mode = cs_n ? 0 : 3;
      end
      default: if (cs_n) m_mode = 0;
    endcase
    m_csq  = cs_n;
    m_held = nh;
  endtask

  task automatic compare(input string tag);
    logic e_run, e_oe, e_busy;
    e_run  = (m_mode == 0) && !m_held;
    e_oe   = e_run && !cs_n;
    e_busy = (m_mode == 2);
    vecs++;
    if (run_en !== e_run || so_oe !== e_oe || wake_busy !== e_busy) begin
      fails++;
      $display("FAIL %s run_en/so_oe/wake_busy actual %b%b%b expected %b%b%b",
               tag, run_en, so_oe, wake_busy, e_run, e_oe, e_busy);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    int nbusy;
    logic [15:0] lfsr;
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; hold_n = 1'b1; sleep_cmd = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    check_val("R1 run_en", int'(run_en), 1);
    check_val("R1 wake_busy", int'(wake_busy), 0);

    cs_n = 1'b0; #0.1;
    check_val("R4 so_oe selected", int'(so_oe), 1);
    tick("R4");

    // sweep of consecutive sck/hold_n pairs
    for (int p = 0; p < 16; p++) begin
      sck = p[0]; hold_n = p[1];
      tick(sck ? "R3" : "R2");
      sck = p[2]; hold_n = p[3];
      tick(sck ? "R3" : "R2");
    end
    sck = 1'b0; hold_n = 1'b1;
    tick("R2");

    // deferred release: hold active, clock high, release, then clock low
    hold_n = 1'b0; tick("R2");
    check_val("R2 held run_en", int'(run_en), 0);
    sck = 1'b1; hold_n = 1'b1; tick("R3");
    check_val("R3 deferred run_en", int'(run_en), 0);
    sck = 1'b0; tick("R3");
    check_val("R3 resumed run_en", int'(run_en), 1);

    // frame without sleep strobe
    cs_n = 1'b1; tick("R6");
    cs_n = 1'b0; tick("R6");
    cs_n = 1'b1; tick("R6");
    check_val("R6 no sleep", int'(run_en), 1);

    // sleeping frame
    cs_n = 1'b0; tick("R5");
    sleep_cmd = 1'b1; tick("R5");
    sleep_cmd = 1'b0; tick("R5");
    cs_n = 1'b1; tick("R5");
    check_val("R5 asleep run_en", int'(run_en), 0);
    for (int k = 0; k < 8; k++) begin
      sck = k[0]; hold_n = k[1]; sleep_cmd = k[2];
      tick("R5");
    end
    sck = 1'b0; hold_n = 1'b1; sleep_cmd = 1'b0;
    tick("R5");
    check_val("R5 still asleep", int'(run_en), 0);

    // wake with early deselect: exact busy length
    cs_n = 1'b0;
    nbusy = 0;
    for (int i = 0; i < int'(W) + 3; i++) begin
      tick("R7");
      if (wake_busy) nbusy++;
      cs_n = (i >= 0) ? 1'b1 : 1'b0;
    end
    check_val("R7 busy length", nbusy, int'(W));
    check_val("R8 resumed", int'(run_en), 1);

    // a later frame must not inherit the old request
    cs_n = 1'b0; tick("R6");
    cs_n = 1'b1; tick("R6");
    check_val("R6 request cleared", int'(run_en), 1);

    // sleep again, wake with chip select held low through expiry
    cs_n = 1'b0; sleep_cmd = 1'b1; tick("R9");
    sleep_cmd = 1'b0; cs_n = 1'b1; tick("R9");
    cs_n = 1'b0;
    for (int i = 0; i < int'(W) + 4; i++) tick("R9");
    check_val("R9 stale run_en", int'(run_en), 0);
    check_val("R9 stale busy", int'(wake_busy), 0);
    cs_n = 1'b1; tick("R9");
    check_val("R9 fresh run_en", int'(run_en), 1);
    cs_n = 1'b0; tick("R9");
    check_val("R9 fresh so_oe", int'(so_oe), 1);

    // pseudo-random run against the model
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sck = lfsr[0];
      hold_n = lfsr[1] | lfsr[2];
      sleep_cmd = (lfsr[5:3] == 3'd0);
      if (lfsr[9:6] == 4'd0) cs_n = ~cs_n;
      tick(m_mode == 0 ? "R4" : "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule